// File: doc/BRIEF.md
# Window Address Serial Uploader

This block runs on the host side and sends the start corner of an image sensor's readout window over a three-wire serial link. The link has a data line, a serial clock and a load strobe. A request carries a 6-bit column start and a 10-bit row start. The block joins them into one 16-bit word and shifts it out most significant bit first. The serial clock is made by dividing the system clock. When the last bit has gone out, the block raises the load strobe. On the rising edge of that strobe, the sensor copies its shift chain into its parallel address registers.

Each bit is driven while the serial clock is low and captured by the sensor on the rising edge. The load strobe rises in the same cycle as the final falling edge of the serial clock, never before it. A busy level spans the whole transfer. A one-cycle done pulse marks its end, and any request that arrives in the meantime is dropped.

Top module: `win_addr_uploader`

## Requirements
- R1: The word sent is {row start, column start}: the row start fills bits 15..6 and the column start fills bits 5..0. Bit 15 goes out first and bit 0 last.
- R2: The data line changes only in cycles where the serial clock is low. It holds steady while the clock is high, so each bit is settled for HALF system cycles before the rising edge that captures it.
- R3: Counting system cycles from the one in which busy rises, the serial clock stays low for HALF cycles and then high for HALF cycles, so its period is 2*HALF cycles. With the default HALF of 4 and a 125 MHz system clock, it runs at 15.6 MHz, below the 20 MHz limit.
- R4: Each transfer makes exactly 16 rising edges on the serial clock.
- R5: The load strobe rises in the same cycle as the 16th falling edge of the serial clock. It stays high for 2*HALF cycles, and the serial clock stays low the whole time.
- R6: After the load strobe falls, all outputs stay low for 2*HALF cycles. Then done is high for exactly one cycle, and busy falls in that same cycle.
- R7: A start request seen while busy is high is ignored. The transfer in progress keeps its word and its timing.
- R8: During reset and when idle, the serial clock, load strobe, busy and done are all low.
- R9: Busy rises in the cycle after a clock edge that sampled start high while the block was idle. The word is taken from the address inputs at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to upload a window address |
| x_start | input | 6 | Column start address |
| y_start | input | 10 | Row start address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk | output | 1 | Serial clock to the sensor |
| sdata | output | 1 | Serial data to the sensor |
| load | output | 1 | Load strobe, active high |

## Verification
Two events share a cycle by design. The final falling edge of the serial clock and the rising edge of the load strobe both happen at one system clock edge. The bench has a model receiver that shifts a bit on every rising edge of the serial clock and latches its word when the load strobe rises. It judges the coincidence in two ways: the latched word must match the request, and the strobe must be high in the first sampled cycle where the clock is low again. A second collision comes from holding start high through the done pulse. In that case a new transfer must begin in the cycle right after done, while a start pulse that arrives in the middle of a transfer must leave the received word unchanged.

// File: rtl/win_addr_uploader.sv
module win_addr_uploader #(
  parameter int X_W  = 6,
  parameter int Y_W  = 10,
  parameter int HALF = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [X_W-1:0] x_start,
  input  logic [Y_W-1:0] y_start,
  output logic           busy,
  output logic           done,
  output logic           sclk,
  output logic           sdata,
  output logic           load
);
  localparam int W   = X_W + Y_W;
  localparam int BW  = $clog2(W);
  localparam int PER = 2 * HALF;
  localparam int CW  = $clog2(PER + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LOAD, S_GAP} st_t;

  st_t           st;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nbit;

  wire [W-1:0] word     = {y_start, x_start};
  wire         half_end = (cnt == CW'(HALF - 1));
  wire         per_end  = (cnt == CW'(PER - 1));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sh    <= '0;
      cnt   <= '0;
      nbit  <= '0;
      sclk  <= 1'b0;
      sdata <= 1'b0;
      load  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st    <= S_SHIFT;
            sdata <= word[W-1];
            sh    <= word << 1;
            cnt   <= '0;
            nbit  <= '0;
          end
        end
        S_SHIFT: begin
          if (half_end) begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (nbit == BW'(W - 1)) begin
                st   <= S_LOAD;
                load <= 1'b1;
              end else begin
                nbit  <= nbit + 1'b1;
                sdata <= sh[W-1];
                sh    <= sh << 1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOAD: begin
          if (per_end) begin
            cnt  <= '0;
            load <= 1'b0;
            st   <= S_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (per_end) begin
            cnt  <= '0;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/win_addr_uploader_chk.sv
module win_addr_uploader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic load
);
  assert_data_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  assert_load_on_last_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load) |-> $fell(sclk));

  assert_quiet_clock_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sclk);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !load && !sclk));

  assert_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !load));

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind win_addr_uploader win_addr_uploader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .sclk(sclk), .sdata(sdata), .load(load)
);

// File: tb/win_addr_uploader_test.sv
module win_addr_uploader_test;
  localparam int HALF   = 4;
  localparam int END_T  = 36 * HALF;
  localparam int SHIFT_T = 32 * HALF;
  localparam int LOAD_T = 34 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] x_start = '0;
  logic [9:0] y_start = '0;
  logic busy, done, sclk, sdata, load;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit timeout = 0;

  always #4 clk = ~clk;

  win_addr_uploader #(.X_W(6), .Y_W(10), .HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_start(x_start), .y_start(y_start),
    .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .load(load)
  );

  // reference model: ph = cycles since acceptance, -1 when idle
  int ph = -1;
  logic [15:0] exp_word = '0;
  logic [15:0] q_words[$];

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) ph = -1;
    else if (ph >= 0 && ph < END_T) ph++;
    else if (start) begin
      ph = 0;
      exp_word = {y_start, x_start};
      q_words.push_back(exp_word);
    end else ph = -1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // receiver model and per-cycle comparison
  logic prev_sclk = 1'b0, prev_load = 1'b0;
  logic [15:0] rx = '0;
  int rises = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_busy, e_done, e_sclk, e_load;
      e_busy = (ph >= 0 && ph < END_T);
      e_done = (ph == END_T);
      e_sclk = (ph >= 0 && ph < SHIFT_T && ((ph / HALF) % 2 == 1));
      e_load = (ph >= SHIFT_T && ph < LOAD_T);
      chk(busy == e_busy, "R9", "busy", busy, e_busy);
      chk(done == e_done, "R6", "done", done, e_done);
      chk(sclk == e_sclk, "R3", "sclk", sclk, e_sclk);
      chk(load == e_load, "R5", "load", load, e_load);
      if (ph >= 0 && ph < SHIFT_T) begin
        logic e_bit;
        e_bit = exp_word[15 - ph / (2 * HALF)];
        chk(sdata == e_bit, "R1", "sdata", sdata, e_bit);
      end
      if (sclk && !prev_sclk) begin
        rx = {rx[14:0], sdata};
        rises++;
      end
      if (load && !prev_load) begin
        logic [15:0] w;
        w = (q_words.size() > 0) ? q_words.pop_front() : 16'hxxxx;
        chk(rises == 16, "R4", "sclk rises", rises, 16);
        chk(rx[15:6] == w[15:6], "R1", "row field", rx[15:6], w[15:6]);
        chk(rx[5:0] == w[5:0], "R1", "column field", rx[5:0], w[5:0]);
        rises = 0;
      end
    end
    prev_sclk = sclk;
    prev_load = load;
  end

  task automatic upload(input logic [5:0] x, input logic [9:0] y);
    @(negedge clk);
    while (busy) @(negedge clk);
    x_start = x; y_start = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sclk && !load, "R8", "reset outputs",
        {busy, done, sclk, load}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !sclk && !load, "R8", "idle outputs", {busy, sclk, load}, 0);

    upload(6'h2A, 10'h155);
    upload(6'h3F, 10'h3FF);
    upload(6'h00, 10'h000);
    upload(6'h01, 10'h200);

    // R7: mid-transfer request with other values must not disturb the word
    @(negedge clk);
    x_start = 6'h15; y_start = 10'h0AA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    x_start = 6'h3C; y_start = 10'h3C3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R7", "no restart from ignored request", busy, 0);

    // start held through done: a new transfer must begin straight after
    x_start = 6'h07; y_start = 10'h1E1; start = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    x_start = 6'h30; y_start = 10'h00F;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", "back-to-back accept", busy, 1);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q_words.size() == 0, "R5", "every word latched", q_words.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule